// File: doc/BRIEF.md
# Tuner Synthesizer Control Register Target on I2C

This block is the register side of a tuning synthesizer. An I2C controller writes into it the 15-bit ratio of the programmable loop divider and a set of control bits: charge-pump current select, two test-mode bits, a tuning-output disable, the band select and three port drive bits. It can also read back one status byte that reports the power-on flag, the loop-lock flag, two logic-level port inputs and a five-level ADC code. SCL and SDA are oversampled by the block clock. The target recognises start and stop conditions itself and drives SDA only through an open-drain pull-down enable.

A write transfer carries data bytes in pairs. The most significant bit of the first byte of each pair decides whether the pair loads the divider or the control bits, and nothing is committed until the second byte of the pair has arrived. A read transfer returns the status byte again and again for as long as the controller acknowledges. The power-on flag is set by reset and by a low-supply indication, and it is cleared when the controller ends a read with a non-acknowledge.

The controller state machine has these states. ST_IDLE waits for a start. ST_ADDR shifts in the address byte. ST_ACK_WAIT waits for the falling SCL edge that ends the eighth bit. ST_ACK_DRIVE holds SDA low through the ninth clock. ST_WR_DATA shifts in a write byte. ST_RD_DATA shifts out the status bits. ST_RD_MACK samples the controller's acknowledge. ST_RD_RELOAD reloads the status for the next byte. ST_SKIP ignores the bus until the next start or stop.

The transitions are as follows. A start goes from any state to ST_ADDR. A stop or a low-supply indication goes from any state to ST_IDLE. ST_ADDR goes to ST_ACK_WAIT on a matching address and to ST_SKIP otherwise. ST_ACK_WAIT goes to ST_ACK_DRIVE on an SCL fall. ST_ACK_DRIVE goes on an SCL fall to ST_RD_DATA for a read and to ST_WR_DATA for a write. ST_WR_DATA goes to ST_ACK_WAIT after eight bits. ST_RD_DATA goes to ST_RD_MACK on the fall after the eighth bit. ST_RD_MACK goes to ST_RD_RELOAD when the controller acknowledges and to ST_SKIP when it does not. ST_RD_RELOAD goes to ST_RD_DATA on an SCL fall.

Top module: `tuner_i2c_regs`

## Requirements
- R1: After reset the divider output is 0, every control output is 0, the power-on flag is 1 and SDA is not driven.
- R2: The address byte is 1,1,0,0,0,addr_sel[1],addr_sel[0],RW, sent MSB first, where RW=1 selects a read. The block acknowledges only a matching address. It ignores every byte of a transfer whose address does not match, and its outputs do not change.
- R3: After each byte the block acknowledges, it pulls SDA low from the SCL fall that ends the eighth bit to the SCL fall that ends the ninth clock, and then releases SDA.
- R4: A write byte with MSB 0 opens a divider pair. Its bits 6..0 become divider[14:8] and the next byte becomes divider[7:0]. The divider changes only once the second byte has arrived.
- R5: A write byte with MSB 1 opens a control pair. In that byte, bit 6 sets pump_hi, bit 5 sets test_mode[1], bit 4 sets test_mode[0] and bit 0 sets tune_off. In the second byte, bit 3 sets band_uhf and bits 2..0 set port_out[2:0]. The controls change only once the second byte has arrived.
- R6: The byte after a completed pair opens a new pair of either kind, chosen by its MSB, so divider and control pairs can follow each other in any order within one transfer.
- R7: A start or stop before a pair is complete, whether between bytes or in the middle of a byte, discards the partial pair and leaves all outputs unchanged.
- R8: In a read, the status byte is {power-on flag, lock_in, 0, ttl_in[1], ttl_in[0], adc_code[2:0]}, sent MSB first. Each bit changes only after an SCL fall.
- R9: If the controller acknowledges a status byte, the block sends the status byte again. If it does not acknowledge, the block releases SDA until the next start or stop.
- R10: A non-acknowledge that ends a read clears the power-on flag. A low-supply indication sets the flag, ends any transfer at once and keeps SDA undriven for as long as it lasts.
- R11: adc_code is the index plus one of the highest asserted comparator in adc_thermo[3:0], or 0 if none is asserted. So 0000, 0001, 0011, 0111 and 1111 give 000, 001, 010, 011 and 100, and the bubble pattern 0101 gives 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low | input | 1 | Low-supply indication |
| scl_in | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the bus |
| sda_drive_low | output | 1 | Open-drain pull-down enable for SDA |
| addr_sel | input | 2 | Pin-selected low address bits |
| lock_in | input | 1 | Loop-lock flag reported in the status byte |
| ttl_in | input | 2 | Logic-level port inputs reported in the status byte |
| adc_thermo | input | 4 | ADC comparator outputs in thermometer form |
| divider | output | 15 | Programmable divider ratio |
| pump_hi | output | 1 | High charge-pump current select |
| test_mode | output | 2 | Test-mode bits, [1] from bit 5 and [0] from bit 4 |
| tune_off | output | 1 | Tuning-voltage output disable |
| band_uhf | output | 1 | Band select, 1 selects the upper band |
| port_out | output | 3 | Port drive bits |

## Verification
Write transfers cover a single divider pair, a single control pair, and a control pair followed by a divider pair in one transfer. The first two show that each field lands in its own register. The mixed transfer shows that the pair type is decided again for every third byte. Partial pairs are cut off in three ways: by a stop between bytes, by a repeated start, and by a stop in the middle of a byte. The repeated-start case is chosen so that a design that failed to discard the partial pair would produce a divider value that differs from the correct one. Reads cover acknowledged repeats, the non-acknowledge that clears the power-on flag, five thermometer codes plus a bubble pattern, and a low-supply event that arrives while the block is driving a 0 bit. The address is exercised with a non-matching pin code and with a wrong fixed prefix.

// File: rtl/tuner_i2c_pkg.sv
`timescale 1ns/1ps
package tuner_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int DIV_W  = 2 * BYTE_W - 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_WR_DATA,
        ST_RD_DATA,
        ST_RD_MACK,
        ST_RD_RELOAD,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/tuner_i2c_line_sync.sv
`timescale 1ns/1ps
module tuner_i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_in};
            sda_p <= {sda_p[STAGES-2:0], sda_in};
            scl_q <= scl_p[STAGES-1];
            sda_q <= sda_p[STAGES-1];
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tuner_adc_enc.sv
`timescale 1ns/1ps
module tuner_adc_enc #(
    parameter int LEVELS = 4,
    localparam int CODE_W = $clog2(LEVELS + 1)
) (
    input  logic [LEVELS-1:0] thermo,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        code = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (thermo[i]) code = CODE_W'(i + 1);
        end
    end
endmodule

// File: rtl/tuner_i2c_fsm.sv
`timescale 1ns/1ps
module tuner_i2c_fsm
    import tuner_i2c_pkg::*;
#(
    parameter logic [4:0] DEV_ID = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_low,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        addr_sel,
    input  logic [BYTE_W-1:0] status_in,
    output logic              sda_drive_low,
    output logic              div_we,
    output logic              ctl_we,
    output logic [BYTE_W-1:0] pair_hi,
    output logic [BYTE_W-1:0] pair_lo,
    output logic              por_clr
);
    tgt_state_e        state, nxt;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sh, tx;
    logic              rd_mode, pair_open, pair_ctl;
    logic              byte_done;
    logic [BYTE_W-1:0] full;

    assign byte_done = scl_rise && (bitcnt == CNT_W'(BYTE_W - 1));
    assign full      = {sh[BYTE_W-2:0], sda_s};

    always_comb begin
        nxt = state;
        if (supply_low || stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_done)
                                  nxt = (sh[BYTE_W-2:0] == {DEV_ID, addr_sel}) ? ST_ACK_WAIT : ST_SKIP;
                ST_ACK_WAIT:  if (scl_fall) nxt = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (scl_fall) nxt = rd_mode ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:   if (byte_done) nxt = ST_ACK_WAIT;
                ST_RD_DATA:   if (scl_fall && bitcnt == CNT_W'(BYTE_W)) nxt = ST_RD_MACK;
                ST_RD_MACK:   if (scl_rise) nxt = sda_s ? ST_SKIP : ST_RD_RELOAD;
                ST_RD_RELOAD: if (scl_fall) nxt = ST_RD_DATA;
                ST_SKIP:      nxt = ST_SKIP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            sh        <= '0;
            tx        <= '0;
            rd_mode   <= 1'b0;
            pair_open <= 1'b0;
            pair_ctl  <= 1'b0;
            pair_hi   <= '0;
            pair_lo   <= '0;
            div_we    <= 1'b0;
            ctl_we    <= 1'b0;
            por_clr   <= 1'b0;
        end else begin
            div_we  <= 1'b0;
            ctl_we  <= 1'b0;
            por_clr <= 1'b0;
            if (supply_low || stop_det || start_det) begin
                bitcnt    <= '0;
                pair_open <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: if (scl_rise) begin
                        sh     <= full;
                        bitcnt <= bitcnt + 1'b1;
                        if (byte_done) rd_mode <= sda_s;
                    end
                    ST_WR_DATA: if (scl_rise) begin
                        sh     <= full;
                        bitcnt <= bitcnt + 1'b1;
                        if (byte_done) begin
                            if (!pair_open) begin
                                pair_open <= 1'b1;
                                pair_ctl  <= full[BYTE_W-1];
                                pair_hi   <= full;
                            end else begin
                                pair_open <= 1'b0;
                                pair_lo   <= full;
                                ctl_we    <= pair_ctl;
                                div_we    <= !pair_ctl;
                            end
                        end
                    end
                    ST_ACK_DRIVE: if (scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) tx <= status_in;
                    end
                    ST_RD_DATA: begin
                        if (scl_rise) bitcnt <= bitcnt + 1'b1;
                        else if (scl_fall && bitcnt != CNT_W'(BYTE_W)) tx <= {tx[BYTE_W-2:0], 1'b0};
                    end
                    ST_RD_MACK: if (scl_rise && sda_s) por_clr <= 1'b1;
                    ST_RD_RELOAD: if (scl_fall) begin
                        tx     <= status_in;
                        bitcnt <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        sda_drive_low = 1'b0;
        if (rst_n && !supply_low) begin
            unique case (state)
                ST_ACK_DRIVE: sda_drive_low = 1'b1;
                ST_RD_DATA:   sda_drive_low = ~tx[BYTE_W-1];
                default:      sda_drive_low = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tuner_reg_bank.sv
`timescale 1ns/1ps
module tuner_reg_bank
    import tuner_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_low,
    input  logic              div_we,
    input  logic              ctl_we,
    input  logic              por_clr,
    input  logic [BYTE_W-1:0] pair_hi,
    input  logic [BYTE_W-1:0] pair_lo,
    output logic [DIV_W-1:0]  divider,
    output logic              pump_hi,
    output logic [1:0]        test_mode,
    output logic              tune_off,
    output logic              band_uhf,
    output logic [2:0]        port_out,
    output logic              por_flag
);
    logic hi_fixed_unused;
    assign hi_fixed_unused = ^{pair_hi[BYTE_W-1], pair_hi[3:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divider   <= '0;
            pump_hi   <= 1'b0;
            test_mode <= '0;
            tune_off  <= 1'b0;
            band_uhf  <= 1'b0;
            port_out  <= '0;
            por_flag  <= 1'b1;
        end else begin
            if (div_we) divider <= {pair_hi[BYTE_W-2:0], pair_lo};
            if (ctl_we) begin
                pump_hi   <= pair_hi[6];
                test_mode <= pair_hi[5:4];
                tune_off  <= pair_hi[0];
                band_uhf  <= pair_lo[3];
                port_out  <= pair_lo[2:0];
            end
            if (supply_low)   por_flag <= 1'b1;
            else if (por_clr) por_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tuner_i2c_regs.sv
`timescale 1ns/1ps
module tuner_i2c_regs
    import tuner_i2c_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_ID      = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_low,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    input  logic [1:0]        addr_sel,
    input  logic              lock_in,
    input  logic [1:0]        ttl_in,
    input  logic [3:0]        adc_thermo,
    output logic [DIV_W-1:0]  divider,
    output logic              pump_hi,
    output logic [1:0]        test_mode,
    output logic              tune_off,
    output logic              band_uhf,
    output logic [2:0]        port_out
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              div_we, ctl_we, por_clr, por_flag;
    logic [BYTE_W-1:0] pair_hi, pair_lo, status;
    logic [2:0]        adc_code;

    tuner_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tuner_adc_enc #(.LEVELS(4)) u_adc (
        .thermo(adc_thermo), .code(adc_code)
    );

    assign status = {por_flag, lock_in, 1'b0, ttl_in, adc_code};

    tuner_i2c_fsm #(.DEV_ID(DEV_ID)) u_fsm (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .addr_sel(addr_sel), .status_in(status),
        .sda_drive_low(sda_drive_low), .div_we(div_we), .ctl_we(ctl_we),
        .pair_hi(pair_hi), .pair_lo(pair_lo), .por_clr(por_clr)
    );

    tuner_reg_bank u_regs (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .div_we(div_we),
        .ctl_we(ctl_we), .por_clr(por_clr), .pair_hi(pair_hi), .pair_lo(pair_lo),
        .divider(divider), .pump_hi(pump_hi), .test_mode(test_mode),
        .tune_off(tune_off), .band_uhf(band_uhf), .port_out(port_out),
        .por_flag(por_flag)
    );
endmodule

// File: rtl/tuner_i2c_regs_chk.sv
`timescale 1ns/1ps
module tuner_i2c_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        supply_low,
    input logic        sda_drive_low,
    input logic        div_we,
    input logic        ctl_we,
    input logic        por_clr,
    input logic        por_flag,
    input logic [14:0] divider,
    input logic [7:0]  ctl_vec
);
    always_comb begin
        if (!rst_n) begin
            a_quiet_in_reset_r1: assert (!sda_drive_low);
        end
    end

    p_quiet_supply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !sda_drive_low);

    p_por_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> por_flag);

    p_por_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (por_clr && !supply_low) |=> !por_flag);

    p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !div_we |=> $stable(divider));

    p_ctl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl_vec));

    p_one_pair_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        div_we |-> !ctl_we);
endmodule

bind tuner_i2c_regs tuner_i2c_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
    .sda_drive_low(sda_drive_low), .div_we(div_we), .ctl_we(ctl_we),
    .por_clr(por_clr), .por_flag(por_flag), .divider(divider),
    .ctl_vec({pump_hi, test_mode, tune_off, band_uhf, port_out})
);

// File: tb/tuner_i2c_regs_tb_top.sv
`timescale 1ns/1ps
module tuner_i2c_regs_tb_top;
    localparam int Q = 200;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, supply_low, m_scl, m_sda, lock_in;
    logic [1:0] addr_sel, ttl_in;
    logic [3:0] adc_thermo;
    logic sda_drive_low, pump_hi, tune_off, band_uhf;
    logic [14:0] divider;
    logic [1:0] test_mode;
    logic [2:0] port_out;
    logic sda_line;
    logic [7:0] ctl_vec;

    assign sda_line = m_sda & ~sda_drive_low;
    assign ctl_vec  = {pump_hi, test_mode, tune_off, band_uhf, port_out};

    tuner_i2c_regs dut_i (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .scl_in(m_scl),
        .sda_in(sda_line), .sda_drive_low(sda_drive_low), .addr_sel(addr_sel),
        .lock_in(lock_in), .ttl_in(ttl_in), .adc_thermo(adc_thermo),
        .divider(divider), .pump_hi(pump_hi), .test_mode(test_mode),
        .tune_off(tune_off), .band_uhf(band_uhf), .port_out(port_out)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct { logic [7:0] v; string req; } exp_t;
    exp_t exp_q[$];
    event rd_done;
    logic [7:0] rd_byte;

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the expected status for every byte the master reads
    initial begin
        forever begin
            exp_t e;
            @(rd_done);
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R8 actual=%0h expected=none", rd_byte);
            end else begin
                e = exp_q.pop_front();
                chk_eq(e.req, {24'h0, rd_byte}, {24'h0, e.v});
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
    endtask

    task automatic wbit(input logic b);
        m_sda = b; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; ack = ~sda_line; #Q; m_scl = 1'b0;
        #(Q/2); rel = ~sda_drive_low; #(Q/2);
    endtask

    task automatic wr(input logic [7:0] b, input string req);
        logic ack, rel;
        send_byte(b, ack, rel);
        chk_eq(req, {31'h0, ack}, 32'h1);
    endtask

    task automatic recv_byte(input logic mack);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; v[i] = sda_line; #Q; m_scl = 1'b0; #Q;
        end
        wbit(mack ? 1'b0 : 1'b1);
        rd_byte = v;
        -> rd_done;
    endtask

    task automatic read_one(input logic [7:0] expv, input string req);
        exp_q.push_back('{expv, req});
        bus_start();
        wr(8'hC5, "R2");
        recv_byte(1'b0);
        bus_stop();
    endtask

    initial begin
        logic ack, rel;
        rst_n = 1'b0; supply_low = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
        lock_in = 1'b1; ttl_in = 2'b10; adc_thermo = 4'b0011; addr_sel = 2'b10;
        #200; rst_n = 1'b1; #200;

        // R1 reset state
        chk_eq("R1", {17'h0, divider}, 32'h0);
        chk_eq("R1", {24'h0, ctl_vec}, 32'h0);
        chk_eq("R1", {31'h0, sda_drive_low}, 32'h0);

        // R8/R9: POR=1 visible, repeated on master ack; NACK then clears POR
        exp_q.push_back('{8'hD2, "R8"});
        exp_q.push_back('{8'hD2, "R9"});
        bus_start();
        wr(8'hC5, "R2");
        recv_byte(1'b1);
        recv_byte(1'b0);
        bus_stop();
        lock_in = 1'b0; ttl_in = 2'b01; adc_thermo = 4'b0000;
        read_one(8'h08, "R10");

        // R11 thermometer encoding
        adc_thermo = 4'b0001; read_one(8'h09, "R11");
        adc_thermo = 4'b0111; read_one(8'h0B, "R11");
        adc_thermo = 4'b1111; read_one(8'h0C, "R11");
        adc_thermo = 4'b0101; read_one(8'h0B, "R11");

        // R2 non-matching addresses
        bus_start();
        send_byte(8'hC0, ack, rel);
        chk_eq("R2", {31'h0, ack}, 32'h0);
        send_byte(8'h12, ack, rel);
        send_byte(8'h34, ack, rel);
        chk_eq("R2", {31'h0, ack}, 32'h0);
        bus_stop();
        bus_start();
        send_byte(8'hD4, ack, rel);
        chk_eq("R2", {31'h0, ack}, 32'h0);
        send_byte(8'h85, ack, rel);
        send_byte(8'h0F, ack, rel);
        bus_stop();
        chk_eq("R2", {17'h0, divider}, 32'h0);
        chk_eq("R2", {24'h0, ctl_vec}, 32'h0);

        // R4 divider pair, R3 acknowledge release
        bus_start();
        wr(8'hC4, "R2");
        send_byte(8'h12, ack, rel);
        chk_eq("R3", {31'h0, ack}, 32'h1);
        chk_eq("R3", {31'h0, rel}, 32'h1);
        chk_eq("R4", {17'h0, divider}, 32'h0);
        wr(8'h34, "R4");
        bus_stop();
        chk_eq("R4", {17'h0, divider}, 32'h1234);

        // R5 control pair
        bus_start();
        wr(8'hC4, "R2");
        wr(8'hDF, "R5");
        wr(8'h0D, "R5");
        bus_stop();
        chk_eq("R5", {24'h0, ctl_vec}, 32'hBD);
        chk_eq("R5", {17'h0, divider}, 32'h1234);

        // R6 control pair then divider pair in one transfer
        bus_start();
        wr(8'hC4, "R2");
        wr(8'h85, "R6");
        wr(8'h02, "R6");
        wr(8'h7F, "R6");
        wr(8'hFF, "R6");
        bus_stop();
        chk_eq("R6", {24'h0, ctl_vec}, 32'h12);
        chk_eq("R6", {17'h0, divider}, 32'h7FFF);

        // R7 partial pair cut by stop, by repeated start, by mid-byte stop
        bus_start();
        wr(8'hC4, "R2");
        wr(8'h01, "R7");
        bus_stop();
        chk_eq("R7", {17'h0, divider}, 32'h7FFF);
        bus_start();
        wr(8'hC4, "R2");
        wr(8'h01, "R7");
        bus_start();
        wr(8'hC4, "R2");
        wr(8'h00, "R7");
        wr(8'h05, "R7");
        bus_stop();
        chk_eq("R7", {17'h0, divider}, 32'h0005);
        bus_start();
        wr(8'hC4, "R2");
        wr(8'h03, "R7");
        wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
        bus_stop();
        chk_eq("R7", {17'h0, divider}, 32'h0005);
        chk_eq("R7", {24'h0, ctl_vec}, 32'h12);

        // R10 low-supply during a read while a 0 bit is driven
        lock_in = 1'b0; ttl_in = 2'b00; adc_thermo = 4'b0000;
        bus_start();
        wr(8'hC5, "R2");
        chk_eq("R8", {31'h0, sda_drive_low}, 32'h1);
        supply_low = 1'b1;
        #100;
        chk_eq("R10", {31'h0, sda_drive_low}, 32'h0);
        #200;
        supply_low = 1'b0;
        #100;
        bus_stop();
        read_one(8'h80, "R10");
        read_one(8'h00, "R10");

        #(4*Q);
        chk_eq("R8", exp_q.size(), 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule